// File: doc/BRIEF.md
# Two-Beam Vehicle Occupancy Counter

This block keeps a running count of the vehicles inside a parking area. Two light beams cross the entrance one behind the other. Each beam has a sensor that reads 1 while a vehicle blocks the beam and 0 while the receiver sees light. A vehicle that drives in blocks the outer beam first, then both beams, then only the inner beam, and then clears both. A vehicle that drives out blocks them in the reverse order. A state machine follows these patterns. Only when a full pattern ends does it send a one-cycle step to a saturating up/down counter.

A vehicle moves slowly compared with the clock, so each sensor pattern can last for any number of cycles. The machine stays in its current step while the inputs do not change. If the inputs break the expected order at any point, the attempt is dropped and the count stays as it was. The step strobe and its direction come out of the block next to the count, so a neighbouring block can react to each event.

Top module: `lot_occupancy_counter`

## Requirements
- R1: While the active-low asynchronous reset is asserted, `occupancy` is 0 and `step_en` is 0, and the machine is idle.
- R2: The input pattern {beam_a,beam_b} = 10, 11, 01, 00, started from idle, raises `occupancy` by one. The new value is visible after the clock edge that samples the final 00.
- R3: The pattern 01, 11, 10, 00, started from idle, lowers `occupancy` by one. The new value is visible after the clock edge that samples the final 00.
- R4: Each pattern of a sequence may be held for any number of cycles, and the result is the same as when each pattern lasts one cycle.
- R5: `step_en` is 1 only while the 00 that completes a sequence is present. It lasts exactly one cycle. `step_up` is 1 with it for an entry and 0 for an exit. `step_en` is 0 in every other cycle.
- R6: A pattern that is neither the current one nor the next one in the sequence returns the machine to idle with no change to `occupancy`. A later complete sequence then counts normally.
- R7: A return to 00 before the final step of a sequence aborts it with no change to `occupancy`.
- R8: An entry when `occupancy` is 1023 (the all-ones value of the 10-bit count) leaves it at 1023.
- R9: An exit when `occupancy` is 0 leaves it at 0.
- R10: Asserting reset in the middle of a sequence clears `occupancy` at once, without waiting for a clock edge, and discards the partial sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| beam_a | input | 1 | Outer beam sensor, 1 = blocked |
| beam_b | input | 1 | Inner beam sensor, 1 = blocked |
| occupancy | output | 10 | Current vehicle count |
| step_en | output | 1 | One-cycle strobe when a sequence completes |
| step_up | output | 1 | Direction of the strobe, 1 = entry |

## Verification
The properties assume that both sensor inputs are already synchronous to the clock and change only between active edges. They also assume that the strobe outputs are judged against the inputs in the same cycle. This matters because the strobe is a combinational function of the current step and the live sensor pattern. The stimulus changes the beams only on the falling clock edge. It holds each pattern for a whole number of cycles, so every sampled pattern is a clean, settled value, and the reset is released away from the rising edge.

// File: rtl/lot_pkg.sv
package lot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IN_A,
        ST_IN_AB,
        ST_IN_B,
        ST_OUT_B,
        ST_OUT_AB,
        ST_OUT_A
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
    } seq_regs_t;

    localparam logic [1:0] PAT_CLEAR = 2'b00;
    localparam logic [1:0] PAT_A     = 2'b10;
    localparam logic [1:0] PAT_B     = 2'b01;
    localparam logic [1:0] PAT_AB    = 2'b11;

endpackage

// File: rtl/beam_seq_fsm.sv
module beam_seq_fsm
    import lot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic beam_a,
    input  logic beam_b,
    output logic step_en,
    output logic step_up
);

    seq_regs_t  seq_d, seq_q;
    logic [1:0] pat;

    assign pat = {beam_a, beam_b};

    // Mealy decode: the step strobe comes straight from the live pattern.
    always_comb begin
        seq_d   = seq_q;
        step_en = 1'b0;
        step_up = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                if (pat == PAT_A)      seq_d.st = ST_IN_A;
                else if (pat == PAT_B) seq_d.st = ST_OUT_B;
            end
            ST_IN_A: begin
                if (pat == PAT_AB)     seq_d.st = ST_IN_AB;
                else if (pat != PAT_A) seq_d.st = ST_IDLE;
            end
            ST_IN_AB: begin
                if (pat == PAT_B)       seq_d.st = ST_IN_B;
                else if (pat != PAT_AB) seq_d.st = ST_IDLE;
            end
            ST_IN_B: begin
                if (pat == PAT_CLEAR) begin
                    seq_d.st = ST_IDLE;
                    step_en  = 1'b1;
                    step_up  = 1'b1;
                end else if (pat != PAT_B) begin
                    seq_d.st = ST_IDLE;
                end
            end
            ST_OUT_B: begin
                if (pat == PAT_AB)     seq_d.st = ST_OUT_AB;
                else if (pat != PAT_B) seq_d.st = ST_IDLE;
            end
            ST_OUT_AB: begin
                if (pat == PAT_A)       seq_d.st = ST_OUT_A;
                else if (pat != PAT_AB) seq_d.st = ST_IDLE;
            end
            ST_OUT_A: begin
                if (pat == PAT_CLEAR) begin
                    seq_d.st = ST_IDLE;
                    step_en  = 1'b1;
                    step_up  = 1'b0;
                end else if (pat != PAT_A) begin
                    seq_d.st = ST_IDLE;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE};
        else        seq_q <= seq_d;
    end

endmodule

// File: rtl/occ_counter.sv
module occ_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic             step_up,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_MIN = '0;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step_en) begin
            if (step_up && cnt_q != CNT_MAX)       cnt_d = cnt_q + 1'b1;
            else if (!step_up && cnt_q != CNT_MIN) cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CNT_MIN;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/lot_occupancy_counter.sv
module lot_occupancy_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             beam_a,
    input  logic             beam_b,
    output logic [CNT_W-1:0] occupancy,
    output logic             step_en,
    output logic             step_up
);

    beam_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .beam_a  (beam_a),
        .beam_b  (beam_b),
        .step_en (step_en),
        .step_up (step_up)
    );

    occ_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .step_up (step_up),
        .count   (occupancy)
    );

endmodule

// File: rtl/lot_occupancy_checker.sv
module lot_occupancy_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             beam_a,
    input logic             beam_b,
    input logic [CNT_W-1:0] occupancy,
    input logic             step_en,
    input logic             step_up
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_STEP_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |-> (!beam_a && !beam_b)); // R5

    AST_STEP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> !step_en); // R5

    AST_ENTRY_INCREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && occupancy != TOP) |=> occupancy == CNT_W'($past(occupancy) + 1'b1)); // R2

    AST_EXIT_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && occupancy != '0) |=> occupancy == CNT_W'($past(occupancy) - 1'b1)); // R3

    AST_NO_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(occupancy)); // R6

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && step_up && occupancy == TOP) |=> occupancy == TOP); // R8

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !step_up && occupancy == '0) |=> occupancy == '0); // R9

endmodule

bind lot_occupancy_counter lot_occupancy_checker #(.CNT_W(CNT_W)) u_lot_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .beam_a    (beam_a),
    .beam_b    (beam_b),
    .occupancy (occupancy),
    .step_en   (step_en),
    .step_up   (step_up)
);

// File: tb/lot_occupancy_counter_bench.sv
`timescale 1ns/1ps
module lot_occupancy_counter_bench;

    localparam int CNT_W = 10;
    localparam int TOP   = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             beam_a = 1'b0;
    logic             beam_b = 1'b0;
    logic [CNT_W-1:0] occupancy;
    logic             step_en;
    logic             step_up;

    int n_checks = 0;
    int n_fail   = 0;
    int model    = 0;
    bit done     = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #4 clk = ~clk;

    lot_occupancy_counter #(.CNT_W(CNT_W)) u_lot_occupancy_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .beam_a    (beam_a),
        .beam_b    (beam_b),
        .occupancy (occupancy),
        .step_en   (step_en),
        .step_up   (step_up)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected counts and compares at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'(occupancy) == e, t, int'(occupancy), e);
            end
        end
    end

    task automatic push_exp(input string tag);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    task automatic drive(input logic [1:0] ab, input int n);
        @(negedge clk);
        {beam_a, beam_b} = ab;
        #1;
        if (ab != 2'b00) check(step_en == 1'b0, "R5 no strobe mid-sequence", int'(step_en), 0);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_step(input bit up, input string tag);
        @(negedge clk);
        {beam_a, beam_b} = 2'b00;
        #1;
        check(step_en == 1'b1, {tag, " R5 strobe on final clear"}, int'(step_en), 1);
        check(step_up == up, {tag, " R5 strobe direction"}, int'(step_up), int'(up));
        @(posedge clk);
        @(negedge clk);
        #1;
        check(step_en == 1'b0, {tag, " R5 strobe lasts one cycle"}, int'(step_en), 0);
    endtask

    task automatic entry(input int h, input string tag);
        drive(2'b10, h);
        drive(2'b11, h);
        drive(2'b01, h);
        finish_step(1'b1, tag);
        if (model < TOP) model++;
        push_exp(tag);
    endtask

    task automatic leave(input int h, input string tag);
        drive(2'b01, h);
        drive(2'b11, h);
        drive(2'b10, h);
        finish_step(1'b0, tag);
        if (model > 0) model--;
        push_exp(tag);
    endtask

    initial begin
        #1;
        check(occupancy == '0, "R1 count in reset", int'(occupancy), 0);
        check(step_en == 1'b0, "R1 strobe in reset", int'(step_en), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(2'b00, 2);
        push_exp("R1 count after release");

        entry(1, "R2 entry");
        entry(7, "R4 entry with long holds");
        leave(1, "R3 exit");
        leave(11, "R4 exit with long holds");
        entry(1, "R2 entry again");

        // R6: 10 then 01 breaks the entry order
        drive(2'b10, 3);
        drive(2'b01, 1);
        drive(2'b00, 4);
        push_exp("R6 deviation keeps count");
        drive(2'b11, 3);
        drive(2'b00, 2);
        push_exp("R6 both blocked from idle ignored");
        entry(2, "R6 full entry after abort");

        // R7: clear before final step
        drive(2'b10, 2);
        drive(2'b11, 2);
        drive(2'b00, 3);
        push_exp("R7 early clear on entry");
        drive(2'b01, 2);
        drive(2'b11, 2);
        drive(2'b00, 3);
        push_exp("R7 early clear on exit");

        // R9: drain and one more exit
        while (model > 0) leave(1, "R3 drain");
        leave(1, "R9 exit at zero");
        leave(2, "R9 exit at zero again");

        // R8: fill past the top
        for (int i = 0; i < TOP + 3; i++) entry(1, "R8 fill");
        check(int'(occupancy) == TOP, "R8 saturated high", int'(occupancy), TOP);
        leave(1, "R8 exit from top");

        // R10: reset in the middle of an entry
        drive(2'b10, 2);
        drive(2'b11, 2);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(occupancy == '0, "R10 asynchronous clear", int'(occupancy), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model = 0;
        drive(2'b01, 2);
        drive(2'b00, 2);
        push_exp("R10 partial sequence discarded");
        entry(1, "R10 entry after reset");

        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule